// File: doc/BRIEF.md
# Read-Return Latency Tracker with Depth Calibration

This block sits in the system clock domain of a double-data-rate memory read path, directly behind a clock-crossing FIFO that is written and read on every cycle. That FIFO hands over one word per system cycle, made of the two halves captured on the rising and the falling memory-clock edge. Most of these words carry nothing. The block decides which ones carry read data. It does not watch a data strobe. Every issued read command goes into a shift line of selectable depth, and the word that arrives in the cycle the command comes out of the line is marked valid. Every other word is dropped.

The arrival delay covers the column access latency, the FIFO crossing and the pad and board delays. Silicon corners can move it by a full cycle, so the depth is chosen at run time. On a start pulse, a calibration walks the depth upward from a programmable lower bound to a programmable upper bound. For each candidate it issues four back-to-back reads of a known pattern and keeps the first depth at which the returned words line up exactly.

The data stream has no back-pressure in either direction. The incoming word is taken on every cycle whether or not it is used, because the FIFO ahead cannot be stalled. The outgoing word is qualified only by `out_valid`, and the consumer must take it in the cycle it is shown. There is no ready signal because nothing upstream could honour one.

Top module: `rd_lat_calib`

## Requirements
- R1: With depth L in `lat_cur`, a `rd_cmd` sampled high in cycle c makes `out_valid` high in cycle c+L, and `out_hi`/`out_lo` then equal the `word_hi`/`word_lo` present in cycle c+L.
- R2: In every cycle that no delayed command lines up with, `out_valid` is low and `out_hi`/`out_lo` are zero.
- R3: Reads issued on consecutive cycles each produce their own strobe on consecutive cycles. None is merged or lost.
- R4: A synchronous reset (`rst` high) sets `lat_cur` to 6, clears `cal_done` and `cal_fail`, and empties the shift line, so a command issued before reset never produces a strobe.
- R5: A `cal_start` pulse runs the candidate depths in ascending order, starting at `lat_min`. Each candidate drives `cal_rd` high for exactly four consecutive cycles. A shorter depth is always tried before a longer one.
- R6: A candidate passes only when exactly four strobes arrive in its window and every strobed word equals {`pat_hi`,`pat_lo`}. On a pass, `lat_cur` takes the candidate, `cal_done` is high for one cycle and normal operation resumes.
- R7: If the candidate equal to (or above) `lat_max` fails, `cal_fail` goes high and stays high until the next `cal_start`, and `lat_cur` becomes the lower bound.
- R8: While calibration runs, `out_valid` stays low, `rd_cmd` has no effect, and a further `cal_start` does not restart the sweep.
- R9: The shift line is emptied before every candidate, so commands issued before the sweep or for an earlier candidate add no strobes to a candidate's window.
- R10: A `lat_min` of 0 is treated as 1. `lat_cur` is never 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_cmd | input | 1 | Read issued this cycle (normal operation) |
| word_hi | input | DW | FIFO output, half captured on the rising memory edge |
| word_lo | input | DW | FIFO output, half captured on the falling memory edge |
| cal_start | input | 1 | Pulse to begin a depth sweep |
| pat_hi | input | DW | Expected high half during calibration |
| pat_lo | input | DW | Expected low half during calibration |
| lat_min | input | LAT_W | Lowest depth to try |
| lat_max | input | LAT_W | Highest depth to try |
| cal_rd | output | 1 | Calibration read request to the command path |
| out_valid | output | 1 | Output word carries read data |
| out_hi | output | DW | Qualified high half, zero when not valid |
| out_lo | output | DW | Qualified low half, zero when not valid |
| lat_cur | output | LAT_W | Depth in use |
| cal_done | output | 1 | One-cycle pulse when a depth was found |
| cal_fail | output | 1 | No depth in the range passed |

## Verification
The bench's memory model returns the pattern a fixed number of cycles after each `cal_rd` and returns unique, changing filler words in every other cycle. A depth off by one therefore always catches one filler word, and a design that ignored the data comparison or the strobe count would accept a wrong depth. Before the sweep, reads are issued right up to the start pulse, and `rd_cmd` is held high during the sweep. A design that kept stale tags, or that let `rd_cmd` into the line, would see extra strobes, reject the true depth and report a failure or show strobes on `out_valid`. A second start pulse in the middle of a sweep shows up as extra `cal_rd` cycles if it restarts the sweep. A lower bound of zero must settle on depth 1, never 0. A burst of back-to-back reads must yield one strobe per read in an unbroken run.

// File: rtl/rlc_pkg.sv
package rlc_pkg;

  typedef enum logic [2:0] {
    CS_IDLE  = 3'd0,
    CS_PREP  = 3'd1,
    CS_ISSUE = 3'd2,
    CS_WAIT  = 3'd3,
    CS_EVAL  = 3'd4
  } cal_state_e;

endpackage

// File: rtl/rlc_delay_line.sv
module rlc_delay_line #(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             tag_in,
  input  logic [LAT_W-1:0] lat_sel,
  output logic             hit
);
  localparam int MAXD = (1 << LAT_W) - 1;

  logic [MAXD:1] stage_q;

  generate
    for (genvar s = 1; s <= MAXD; s++) begin : g_stage
      if (s == 1) begin : g_head
        always_ff @(posedge clk) begin
          if (rst || flush) stage_q[s] <= 1'b0;
          else              stage_q[s] <= tag_in;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst || flush) stage_q[s] <= 1'b0;
          else              stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  always_comb begin
    hit = 1'b0;
    for (int s = 1; s <= MAXD; s++) begin
      if (lat_sel == LAT_W'(s)) hit = stage_q[s];
    end
  end

endmodule

// File: rtl/rlc_out_gate.sv
module rlc_out_gate #(
  parameter int DW = 16
) (
  input  logic          hit,
  input  logic          busy,
  input  logic [DW-1:0] word_hi,
  input  logic [DW-1:0] word_lo,
  input  logic [DW-1:0] pat_hi,
  input  logic [DW-1:0] pat_lo,
  output logic          match,
  output logic          out_valid,
  output logic [DW-1:0] out_hi,
  output logic [DW-1:0] out_lo
);
  assign match     = (word_hi == pat_hi) && (word_lo == pat_lo);
  assign out_valid = hit && !busy;
  assign out_hi    = out_valid ? word_hi : '0;
  assign out_lo    = out_valid ? word_lo : '0;

endmodule

// File: rtl/rlc_cal_ctrl.sv
module rlc_cal_ctrl
  import rlc_pkg::*;
#(
  parameter int LAT_W     = 4,
  parameter int LAT_RESET = 6,
  parameter int CAL_READS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cal_start,
  input  logic [LAT_W-1:0] lat_min,
  input  logic [LAT_W-1:0] lat_max,
  input  logic             hit,
  input  logic             match,
  output logic             busy,
  output logic             cal_rd,
  output logic             flush,
  output logic [LAT_W-1:0] lat_sel,
  output logic [LAT_W-1:0] lat_cur,
  output logic             cal_done,
  output logic             cal_fail
);
  localparam int MAXD = (1 << LAT_W) - 1;
  localparam int ICW  = $clog2(CAL_READS + 1);
  localparam int HCW  = $clog2(CAL_READS + MAXD + 2);

  cal_state_e       st_q;
  logic [LAT_W-1:0] cand_q, lat_q, min_eff;
  logic [ICW-1:0]   icnt_q;
  logic [LAT_W-1:0] wcnt_q;
  logic [HCW-1:0]   hits_q;
  logic             miss_q;
  logic             done_q, fail_q;
  logic             window, pass;

  assign min_eff = (lat_min == '0) ? LAT_W'(1) : lat_min;
  assign window  = (st_q == CS_ISSUE) || (st_q == CS_WAIT);
  assign pass    = (hits_q == HCW'(CAL_READS)) && !miss_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= CS_IDLE;
      cand_q <= '0;
      lat_q  <= LAT_W'(LAT_RESET);
      icnt_q <= '0;
      wcnt_q <= '0;
      hits_q <= '0;
      miss_q <= 1'b0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (window && hit) begin
        hits_q <= hits_q + 1'b1;
        if (!match) miss_q <= 1'b1;
      end
      case (st_q)
        CS_IDLE: begin
          if (cal_start) begin
            cand_q <= min_eff;
            fail_q <= 1'b0;
            st_q   <= CS_PREP;
          end
        end
        CS_PREP: begin
          icnt_q <= '0;
          hits_q <= '0;
          miss_q <= 1'b0;
          st_q   <= CS_ISSUE;
        end
        CS_ISSUE: begin
          icnt_q <= icnt_q + 1'b1;
          if (icnt_q == ICW'(CAL_READS - 1)) begin
            wcnt_q <= '0;
            st_q   <= CS_WAIT;
          end
        end
        CS_WAIT: begin
          wcnt_q <= wcnt_q + 1'b1;
          if (wcnt_q == LAT_W'(MAXD)) st_q <= CS_EVAL;
        end
        CS_EVAL: begin
          if (pass) begin
            lat_q  <= cand_q;
            done_q <= 1'b1;
            st_q   <= CS_IDLE;
          end else if (cand_q >= lat_max) begin
            lat_q  <= min_eff;
            fail_q <= 1'b1;
            st_q   <= CS_IDLE;
          end else begin
            cand_q <= cand_q + 1'b1;
            st_q   <= CS_PREP;
          end
        end
        default: st_q <= CS_IDLE;
      endcase
    end
  end

  assign busy     = (st_q != CS_IDLE);
  assign cal_rd   = (st_q == CS_ISSUE);
  assign flush    = (st_q == CS_PREP);
  assign lat_sel  = busy ? cand_q : lat_q;
  assign lat_cur  = lat_q;
  assign cal_done = done_q;
  assign cal_fail = fail_q;

endmodule

// File: rtl/rd_lat_calib.sv
module rd_lat_calib #(
  parameter int DW        = 16,
  parameter int LAT_W     = 4,
  parameter int LAT_RESET = 6,
  parameter int CAL_READS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_cmd,
  input  logic [DW-1:0]    word_hi,
  input  logic [DW-1:0]    word_lo,
  input  logic             cal_start,
  input  logic [DW-1:0]    pat_hi,
  input  logic [DW-1:0]    pat_lo,
  input  logic [LAT_W-1:0] lat_min,
  input  logic [LAT_W-1:0] lat_max,
  output logic             cal_rd,
  output logic             out_valid,
  output logic [DW-1:0]    out_hi,
  output logic [DW-1:0]    out_lo,
  output logic [LAT_W-1:0] lat_cur,
  output logic             cal_done,
  output logic             cal_fail
);
  logic             busy, flush, hit, match, tag_in;
  logic [LAT_W-1:0] lat_sel;

  assign tag_in = busy ? cal_rd : rd_cmd;

  rlc_delay_line #(.LAT_W(LAT_W)) u_dly (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .tag_in  (tag_in),
    .lat_sel (lat_sel),
    .hit     (hit)
  );

  rlc_out_gate #(.DW(DW)) u_gate (
    .hit       (hit),
    .busy      (busy),
    .word_hi   (word_hi),
    .word_lo   (word_lo),
    .pat_hi    (pat_hi),
    .pat_lo    (pat_lo),
    .match     (match),
    .out_valid (out_valid),
    .out_hi    (out_hi),
    .out_lo    (out_lo)
  );

  rlc_cal_ctrl #(
    .LAT_W     (LAT_W),
    .LAT_RESET (LAT_RESET),
    .CAL_READS (CAL_READS)
  ) u_cal (
    .clk       (clk),
    .rst       (rst),
    .cal_start (cal_start),
    .lat_min   (lat_min),
    .lat_max   (lat_max),
    .hit       (hit),
    .match     (match),
    .busy      (busy),
    .cal_rd    (cal_rd),
    .flush     (flush),
    .lat_sel   (lat_sel),
    .lat_cur   (lat_cur),
    .cal_done  (cal_done),
    .cal_fail  (cal_fail)
  );

endmodule

// File: rtl/rlc_checker.sv
module rlc_checker #(
  parameter int DW    = 16,
  parameter int LAT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cal_rd,
  input logic             out_valid,
  input logic [DW-1:0]    out_hi,
  input logic [DW-1:0]    out_lo,
  input logic [LAT_W-1:0] lat_cur,
  input logic             cal_done,
  input logic             cal_fail
);
  AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_hi == '0 && out_lo == '0)); // R2
  AST_NO_VALID_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid); // R4
  AST_CALRD_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_rd) |=> cal_rd); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    cal_done |=> !cal_done); // R6
  AST_DONE_NOT_FAIL: assert property (@(posedge clk) disable iff (rst)
    cal_done |-> !cal_fail); // R7
  AST_QUIET_CAL: assert property (@(posedge clk) disable iff (rst)
    cal_rd |-> !out_valid); // R8
  AST_LAT_NONZERO: assert property (@(posedge clk) disable iff (rst)
    lat_cur != '0); // R10
endmodule

bind rd_lat_calib rlc_checker #(.DW(DW), .LAT_W(LAT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cal_rd    (cal_rd),
  .out_valid (out_valid),
  .out_hi    (out_hi),
  .out_lo    (out_lo),
  .lat_cur   (lat_cur),
  .cal_done  (cal_done),
  .cal_fail  (cal_fail)
);

// File: tb/tb_rd_lat_calib.sv
`timescale 1ns/1ps
module tb_rd_lat_calib;
  localparam int DW = 16;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_cmd = 1'b0;
  logic          cal_start = 1'b0;
  logic [DW-1:0] word_hi, word_lo;
  logic [DW-1:0] pat_hi = 16'hC3A5;
  logic [DW-1:0] pat_lo = 16'h3C5A;
  logic [LW-1:0] lat_min = 4'd5;
  logic [LW-1:0] lat_max = 4'd6;
  logic          cal_rd, out_valid, cal_done, cal_fail;
  logic [DW-1:0] out_hi, out_lo;
  logic [LW-1:0] lat_cur;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int model_t = 5;
  int exp_lat = 6;
  logic model_on = 1'b0;
  logic sb_on = 1'b0;
  logic [31:0] bhist = '0;
  logic [31:0] mhist = '0;
  logic ev;

  rd_lat_calib dut (
    .clk(clk), .rst(rst), .rd_cmd(rd_cmd), .word_hi(word_hi), .word_lo(word_lo),
    .cal_start(cal_start), .pat_hi(pat_hi), .pat_lo(pat_lo),
    .lat_min(lat_min), .lat_max(lat_max), .cal_rd(cal_rd),
    .out_valid(out_valid), .out_hi(out_hi), .out_lo(out_lo),
    .lat_cur(lat_cur), .cal_done(cal_done), .cal_fail(cal_fail)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) bhist <= '0;
    else     bhist <= {bhist[30:0], rd_cmd};
    mhist <= {mhist[30:0], cal_rd};
  end

  // memory model: pattern returns model_t cycles after each calibration read
  always_comb begin
    if (model_on && mhist[model_t-1]) begin
      word_hi = pat_hi;
      word_lo = pat_lo;
    end else begin
      word_hi = cyc[15:0];
      word_lo = ~cyc[15:0];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  // per-cycle scoreboard in normal operation (R1, R2)
  always @(negedge clk) begin
    if (sb_on) begin
      ev = bhist[exp_lat-1];
      chk(out_valid === ev, "R1", "valid timing", int'(out_valid), int'(ev));
      chk(out_hi === (ev ? word_hi : '0) && out_lo === (ev ? word_lo : '0),
          "R2", "gated data", int'(out_hi), ev ? int'(word_hi) : 0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  task automatic t_reset();
    int seen = 0;
    rst = 1'b1;
    step(3);
    rst = 1'b0;
    @(negedge clk);
    chk(int'(lat_cur) == 6, "R4", "reset latency", int'(lat_cur), 6);
    chk(!out_valid && !cal_done && !cal_fail, "R4", "reset flags",
        int'({out_valid, cal_done, cal_fail}), 0);
    step(1);
    rd_cmd = 1'b1;
    step(2);
    rd_cmd = 1'b0;
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (out_valid) seen++;
      step(1);
    end
    chk(seen == 0, "R4", "stale strobes after reset", seen, 0);
  endtask

  task automatic t_single(input int lat);
    int nv = 0;
    exp_lat = lat;
    step(20);
    sb_on = 1'b1;
    for (int i = 0; i < 32; i++) begin
      rd_cmd = (i == 0 || i == 3 || i == 4 || i == 9);
      @(negedge clk);
      if (out_valid) nv++;
      step(1);
    end
    rd_cmd = 1'b0;
    sb_on = 1'b0;
    chk(nv == 4, "R1", "strobe count for scattered reads", nv, 4);
  endtask

  task automatic t_burst(input int lat);
    int nv = 0;
    int run = 0;
    int best = 0;
    exp_lat = lat;
    step(20);
    sb_on = 1'b1;
    for (int i = 0; i < 40; i++) begin
      rd_cmd = (i < 12);
      @(negedge clk);
      if (out_valid) begin
        nv++;
        run++;
        if (run > best) best = run;
      end else begin
        run = 0;
      end
      step(1);
    end
    rd_cmd = 1'b0;
    sb_on = 1'b0;
    chk(nv == 12, "R3", "burst strobe count", nv, 12);
    chk(best == 12, "R3", "burst unbroken run", best, 12);
  endtask

  task automatic t_cal(input int tt, input int mn, input int mx, input int exp_l,
                       input bit exp_f, input int ncand, input bit restart);
    int nrd = 0;
    int nv = 0;
    int ndone = 0;
    int tail = -1;
    model_on = 1'b1;
    model_t = tt;
    lat_min = LW'(mn);
    lat_max = LW'(mx);
    step(1);
    rd_cmd = 1'b1;          // stale reads right before the sweep (R9)
    step(2);
    cal_start = 1'b1;
    step(1);
    cal_start = 1'b0;
    for (int i = 0; i < 600 && tail != 0; i++) begin
      if (restart) cal_start = (i == 10);
      @(negedge clk);
      if (cal_rd) nrd++;
      if (cal_done) ndone++;
      if (tail < 0 && out_valid) nv++;
      if (tail < 0 && (cal_done || cal_fail)) tail = 3;
      else if (tail > 0) tail--;
      step(1);
    end
    cal_start = 1'b0;
    rd_cmd = 1'b0;
    step(20);
    model_on = 1'b0;
    @(negedge clk);
    chk(int'(lat_cur) == exp_l, exp_f ? "R7" : "R6", "chosen latency",
        int'(lat_cur), exp_l);
    chk(cal_fail == exp_f, "R7", "fail flag", int'(cal_fail), int'(exp_f));
    chk(ndone == (exp_f ? 0 : 1), "R6", "done pulse cycles", ndone, exp_f ? 0 : 1);
    chk(nrd == 4 * ncand, "R5", "calibration read cycles", nrd, 4 * ncand);
    chk(nv == 0, "R8", "strobes during sweep", nv, 0);
    step(1);
  endtask

  initial begin
    t_reset();
    t_single(6);
    t_burst(6);
    t_cal(5, 5, 6, 5, 1'b0, 1, 1'b0);   // R5 R9: shorter depth wins first
    t_single(5);
    t_cal(6, 5, 6, 6, 1'b0, 2, 1'b1);   // R5 R8: 5 fails, 6 passes, restart ignored
    t_single(6);
    t_burst(6);
    t_cal(9, 5, 6, 5, 1'b1, 2, 1'b0);   // R7: nothing matches
    t_single(5);
    t_cal(1, 0, 2, 1, 1'b0, 1, 1'b0);   // R10: zero bound treated as one
    t_single(1);
    finish_up();
  end

endmodule